// File: doc/BRIEF.md
# Floating-point condition predicate evaluator

This block decides whether a floating-point conditional operation (branch, set or trap on condition) is satisfied. It takes a condition predicate and the four condition flags of the floating-point status: negative, zero, infinity and not-a-number. It returns a true/false verdict, marks predicates outside the defined range as illegal, and says whether the branch-on-unordered exception flag has to be raised. An exception is due when a test that is not IEEE-aware meets a not-a-number flag.

The same evaluation also drives the loop form of the conditional branch. A 32-bit loop register enters the block. When the condition holds, the loop falls through and the register comes back unchanged. When it fails, the low 16 bits are counted down, the high 16 bits are kept, and a branch-taken flag is returned. Instruction fetch, target address arithmetic and trap delivery belong to the surrounding pipeline.

The evaluation is pure combinational logic. A parameter selects either a registered output stage, with results one clock after the request, or a direct combinational path.

Top module: `fp_cond_eval`

## Requirements
- R1: Only the low 6 bits of the `pred` word take part. The bits above bit 5 have no effect on any output.
- R2: A predicate with bit 5 set (value 0x20 to 0x3F) sets `illegal`. It forces `result`, `set_bsun` and `dec_branch` to 0 and returns `cnt_in` unchanged on `cnt_out`.
- R3: For a legal predicate with bit 4 set, `set_bsun` equals `flag_nan`. For a legal predicate with bit 4 clear, `set_bsun` is 0.
- R4: Let c be the low 4 predicate bits. If bit 3 of c is set, the base test is chosen by c XOR 0xF and its verdict is inverted. Otherwise the base test is c itself, used as is.
- R5: The base tests 0 to 3 are as follows. Test 0 is always false. Test 1 is true when Z is set. Test 2 is true when NAN, Z and N are all clear. Test 3 is true when Z is set, or when NAN and N are both clear.
- R6: The base tests 4 to 7 are as follows. Test 4 is true when N is set and NAN and Z are clear. Test 5 is true when Z is set, or when N is set and NAN is clear. Test 6 is true when NAN and Z are both clear. Test 7 is true when NAN is clear. The infinity flag affects no test.
- R7: The exception byte `exc_in` is cleared before evaluation and has no effect. `exc_out` is zero except at bit 7, the branch-on-unordered position, which equals `set_bsun`.
- R8: When the condition is true, `cnt_out` equals `cnt_in` and `dec_branch` is 0.
- R9: When a legal condition is false, `cnt_out` keeps bits 31:16 of `cnt_in` and carries bits 15:0 minus one, wrapping modulo 2^16. `dec_branch` is 1 exactly when bits 15:0 of `cnt_in` were nonzero.
- R10: With `REG_OUT`=1, every output shows the evaluation of the inputs at the previous rising clock edge, and `result_valid` is the previous `req_valid`. With `REG_OUT`=0, the outputs follow the inputs in the same cycle and `result_valid` equals `req_valid`.
- R11: While `rst_n` is low, the registered outputs are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | An evaluation is requested this cycle |
| pred | input | 16 | Predicate word; bits 5:0 are the predicate |
| flag_n | input | 1 | Negative condition flag |
| flag_z | input | 1 | Zero condition flag |
| flag_inf | input | 1 | Infinity condition flag |
| flag_nan | input | 1 | Not-a-number condition flag |
| exc_in | input | 8 | Current exception byte (cleared by the evaluation) |
| cnt_in | input | 32 | Loop register before the decrement-and-branch step |
| result_valid | output | 1 | Outputs hold a valid evaluation |
| result | output | 1 | Condition verdict |
| illegal | output | 1 | Predicate out of the defined range |
| set_bsun | output | 1 | Raise the branch-on-unordered exception |
| exc_out | output | 8 | Exception byte after evaluation |
| cnt_out | output | 32 | Loop register after the step |
| dec_branch | output | 1 | Loop branch is taken |

## Verification
The bench sweeps every 6-bit predicate against all sixteen flag combinations, with garbage in the upper predicate bits and in the exception byte. Each vector runs through both the registered and the combinational variants.

A decoder that negated the predicate by inverting the result without complementing the code would give wrong verdicts for codes 8 to 15. A decoder that ignored bit 5 would report a legal verdict, and possibly an exception, for codes 0x20 and up.

Loop registers with a zero low half, a low half of one, a low half of 0x8000 and all ones cover the decrement corners. If the zero case were mishandled, the loop would branch at the terminal count. If the borrow leaked, the high half would change.

// File: rtl/fpcc_pkg.sv
package fpcc_pkg;

    localparam int PRED_KEEP = 6;
    localparam int CODE_W    = 4;
    localparam int TEST_W    = 3;

    typedef enum logic [TEST_W-1:0] {
        BT_NEVER   = 3'd0,
        BT_EQUAL   = 3'd1,
        BT_ABOVE   = 3'd2,
        BT_ABOVE_EQ= 3'd3,
        BT_BELOW   = 3'd4,
        BT_BELOW_EQ= 3'd5,
        BT_UNEQUAL = 3'd6,
        BT_ORDERED = 3'd7
    } base_test_e;

    typedef struct packed {
        logic n;
        logic z;
        logic nan;
    } cc_flags_t;

    typedef struct packed {
        logic       illegal;
        logic       nonaware;
        logic       invert;
        base_test_e test;
    } pred_dec_t;

endpackage

// File: rtl/fpcc_pred_decode.sv
module fpcc_pred_decode
    import fpcc_pkg::*;
(
    input  logic [PRED_KEEP-1:0] sel,
    output pred_dec_t            dec
);
    logic [CODE_W-1:0] code;

    always_comb begin
        code         = sel[CODE_W-1:0];
        dec.illegal  = sel[5];
        dec.nonaware = sel[4];
        dec.invert   = code[CODE_W-1];
        if (code[CODE_W-1]) begin
            code = code ^ {CODE_W{1'b1}};
        end
        dec.test = base_test_e'(code[TEST_W-1:0]);
    end
endmodule

// File: rtl/fpcc_base_test.sv
module fpcc_base_test
    import fpcc_pkg::*;
(
    input  base_test_e test,
    input  cc_flags_t  cc,
    output logic       hit
);
    always_comb begin
        unique case (test)
            BT_NEVER:    hit = 1'b0;
            BT_EQUAL:    hit = cc.z;
            BT_ABOVE:    hit = !cc.nan && !cc.z && !cc.n;
            BT_ABOVE_EQ: hit = cc.z || (!cc.nan && !cc.n);
            BT_BELOW:    hit = cc.n && !cc.nan && !cc.z;
            BT_BELOW_EQ: hit = cc.z || (cc.n && !cc.nan);
            BT_UNEQUAL:  hit = !cc.nan && !cc.z;
            BT_ORDERED:  hit = !cc.nan;
            default:     hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/fpcc_loop_count.sv
module fpcc_loop_count #(
    parameter int CNT_W  = 32,
    parameter int LOOP_W = 16
) (
    input  logic             hold,
    input  logic [CNT_W-1:0] cnt_in,
    output logic [CNT_W-1:0] cnt_out,
    output logic             taken
);
    localparam int HI_W = CNT_W - LOOP_W;

    logic [LOOP_W-1:0] low;
    logic [HI_W-1:0]   high;

    always_comb begin
        low  = cnt_in[LOOP_W-1:0];
        high = cnt_in[CNT_W-1:LOOP_W];
        if (hold) begin
            cnt_out = cnt_in;
            taken   = 1'b0;
        end else begin
            cnt_out = {high, low - LOOP_W'(1)};
            taken   = |low;
        end
    end
endmodule

// File: rtl/fp_cond_eval.sv
module fp_cond_eval
    import fpcc_pkg::*;
#(
    parameter int PRED_W   = 16,
    parameter int CNT_W    = 32,
    parameter int LOOP_W   = 16,
    parameter int EXC_W    = 8,
    parameter int BSUN_BIT = 7,
    parameter bit REG_OUT  = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [PRED_W-1:0] pred,
    input  logic              flag_n,
    input  logic              flag_z,
    input  logic              flag_inf,
    input  logic              flag_nan,
    input  logic [EXC_W-1:0]  exc_in,
    input  logic [CNT_W-1:0]  cnt_in,
    output logic              result_valid,
    output logic              result,
    output logic              illegal,
    output logic              set_bsun,
    output logic [EXC_W-1:0]  exc_out,
    output logic [CNT_W-1:0]  cnt_out,
    output logic              dec_branch
);
    // Inputs that the evaluation deliberately discards.
    logic unused_inputs;
    assign unused_inputs = &{1'b0, pred[PRED_W-1:PRED_KEEP], flag_inf, exc_in};

    pred_dec_t dec;
    cc_flags_t cc;
    logic      base_hit;
    logic      verdict_c;
    logic      bsun_c;
    logic [EXC_W-1:0] exc_c;
    logic [CNT_W-1:0] cnt_c;
    logic      branch_c;

    assign cc = '{n: flag_n, z: flag_z, nan: flag_nan};

    fpcc_pred_decode u_decode (
        .sel (pred[PRED_KEEP-1:0]),
        .dec (dec)
    );

    fpcc_base_test u_test (
        .test (dec.test),
        .cc   (cc),
        .hit  (base_hit)
    );

    always_comb begin
        verdict_c = !dec.illegal && (base_hit ^ dec.invert);
        bsun_c    = !dec.illegal && dec.nonaware && flag_nan;
        exc_c           = '0;
        exc_c[BSUN_BIT] = bsun_c;
    end

    fpcc_loop_count #(.CNT_W(CNT_W), .LOOP_W(LOOP_W)) u_loop (
        .hold    (dec.illegal || verdict_c),
        .cnt_in  (cnt_in),
        .cnt_out (cnt_c),
        .taken   (branch_c)
    );

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    result_valid <= 1'b0;
                    result       <= 1'b0;
                    illegal      <= 1'b0;
                    set_bsun     <= 1'b0;
                    exc_out      <= '0;
                    cnt_out      <= '0;
                    dec_branch   <= 1'b0;
                end else begin
                    result_valid <= req_valid;
                    result       <= verdict_c;
                    illegal      <= dec.illegal;
                    set_bsun     <= bsun_c;
                    exc_out      <= exc_c;
                    cnt_out      <= cnt_c;
                    dec_branch   <= branch_c;
                end
            end

            p_valid_delay_r10: assert property (@(posedge clk) disable iff (!rst_n)
                result_valid == $past(req_valid));

            p_illegal_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
                illegal |-> (!result && !set_bsun && !dec_branch));

            p_bsun_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
                set_bsun |-> ($past(flag_nan) && $past(pred[4])));

            p_true_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (result_valid && result) |-> (cnt_out == $past(cnt_in) && !dec_branch));

            p_upper_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
                result_valid |-> (cnt_out[CNT_W-1:LOOP_W] == $past(cnt_in[CNT_W-1:LOOP_W])));

            p_exc_only_bsun_r7: assert property (@(posedge clk) disable iff (!rst_n)
                $countones(exc_out) == (set_bsun ? 1 : 0));
        end else begin : g_comb
            always_comb begin
                result_valid = req_valid;
                result       = verdict_c;
                illegal      = dec.illegal;
                set_bsun     = bsun_c;
                exc_out      = exc_c;
                cnt_out      = cnt_c;
                dec_branch   = branch_c;
            end

            p_illegal_quiet_comb_r2: assert property (@(posedge clk) disable iff (!rst_n)
                illegal |-> (!result && !set_bsun && !dec_branch));
        end
    endgenerate
endmodule

// File: tb/fp_cond_eval_test.sv
module fp_cond_eval_test;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic        rst_n;
    logic        req_valid;
    logic [15:0] pred;
    logic        flag_n, flag_z, flag_inf, flag_nan;
    logic [7:0]  exc_in;
    logic [31:0] cnt_in;

    logic        r_valid, r_res, r_ill, r_bsun, r_br;
    logic [7:0]  r_exc;
    logic [31:0] r_cnt;
    logic        c_valid, c_res, c_ill, c_bsun, c_br;
    logic [7:0]  c_exc;
    logic [31:0] c_cnt;

    fp_cond_eval #(.REG_OUT(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .pred(pred),
        .flag_n(flag_n), .flag_z(flag_z), .flag_inf(flag_inf), .flag_nan(flag_nan),
        .exc_in(exc_in), .cnt_in(cnt_in),
        .result_valid(r_valid), .result(r_res), .illegal(r_ill), .set_bsun(r_bsun),
        .exc_out(r_exc), .cnt_out(r_cnt), .dec_branch(r_br)
    );

    fp_cond_eval #(.REG_OUT(1'b0)) uut_comb (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .pred(pred),
        .flag_n(flag_n), .flag_z(flag_z), .flag_inf(flag_inf), .flag_nan(flag_nan),
        .exc_in(exc_in), .cnt_in(cnt_in),
        .result_valid(c_valid), .result(c_res), .illegal(c_ill), .set_bsun(c_bsun),
        .exc_out(c_exc), .cnt_out(c_cnt), .dec_branch(c_br)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp_v);
        end
    endtask

    // Behavioural reference built from the requirements.
    logic        e_ill, e_res, e_bsun, e_br;
    logic [7:0]  e_exc;
    logic [31:0] e_cnt;
    string       res_tag;

    task automatic model(input int p, input bit n, input bit z, input bit nan,
                         input logic [31:0] c);
        int  code;
        bit  neg, base;
        int  low;
        e_ill = (p >= 32);
        code  = p % 16;
        neg   = (code >= 8);
        if (neg) code = 15 - code;
        case (code)
            0: base = 0;
            1: base = z;
            2: base = !nan && !z && !n;
            3: base = z || (!nan && !n);
            4: base = n && !nan && !z;
            5: base = z || (n && !nan);
            6: base = !nan && !z;
            default: base = !nan;
        endcase
        if (e_ill) begin
            e_res  = 0;
            e_bsun = 0;
            res_tag = "R1 R2";
        end else begin
            e_res  = neg ? !base : base;
            e_bsun = ((p % 32) >= 16) && nan;
            res_tag = (code < 4) ? (neg ? "R1 R4 R5" : "R1 R5") : (neg ? "R1 R4 R6" : "R1 R6");
        end
        e_exc = e_bsun ? 8'h80 : 8'h00;
        if (e_ill || e_res) begin
            e_cnt = c;
            e_br  = 0;
        end else begin
            low   = int'(c[15:0]);
            e_br  = (low != 0);
            e_cnt = {c[31:16], 16'(low - 1)};
        end
    endtask

    task automatic compare(input string where, input logic v, input logic rs, input logic il,
                           input logic bs, input logic [7:0] ex, input logic [31:0] cn,
                           input logic br);
        chk({where, " R10 valid"}, 32'(v), 32'(1));
        chk({where, " ", res_tag, " result"}, 32'(rs), 32'(e_res));
        chk({where, " R2 illegal"}, 32'(il), 32'(e_ill));
        chk({where, " R3 set_bsun"}, 32'(bs), 32'(e_bsun));
        chk({where, " R7 exc_out"}, 32'(ex), 32'(e_exc));
        chk({where, e_res ? " R8 cnt_out" : " R9 cnt_out"}, cn, e_cnt);
        chk({where, e_res ? " R8 dec_branch" : " R9 dec_branch"}, 32'(br), 32'(e_br));
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL R10 watchdog: actual hung expected finished");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] cval;
        rst_n = 1'b0; req_valid = 1'b0; pred = '0;
        flag_n = 0; flag_z = 0; flag_inf = 0; flag_nan = 0;
        exc_in = '0; cnt_in = '0;
        repeat (3) @(posedge clk);
        #1;
        // R11: reset state of the registered outputs.
        chk("R11 valid", 32'(r_valid), 32'(0));
        chk("R11 result", 32'(r_res), 32'(0));
        chk("R11 cnt_out", r_cnt, 32'(0));
        chk("R11 exc_out", 32'(r_exc), 32'(0));
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < 1024; i++) begin
            case (i % 5)
                0: cval = 32'h1234_0000;
                1: cval = 32'hABCD_0001;
                2: cval = 32'hFFFF_FFFF;
                3: cval = 32'h5A5A_8000;
                default: cval = 32'(i * 32'h0001_0347);
            endcase
            @(negedge clk);
            req_valid = 1'b1;
            pred      = {10'(i * 37 + 5), 6'(i)};
            flag_n    = i[6];
            flag_z    = i[7];
            flag_inf  = i[8];
            flag_nan  = i[9];
            exc_in    = 8'(i * 13 + 1);
            cnt_in    = cval;
            model(i % 64, i[6], i[7], i[9], cval);
            #1;
            compare("comb", c_valid, c_res, c_ill, c_bsun, c_exc, c_cnt, c_br);
            @(posedge clk);
            #1;
            compare("reg", r_valid, r_res, r_ill, r_bsun, r_exc, r_cnt, r_br);
        end

        @(negedge clk);
        req_valid = 1'b0;
        #1;
        chk("R10 comb valid low", 32'(c_valid), 32'(0));
        @(posedge clk);
        #1;
        chk("R10 reg valid low", 32'(r_valid), 32'(0));

        summary();
        $finish;
    end
endmodule